// File: doc/BRIEF.md
# Bit-Clock Ratio Detector and PDM Clock Generator

This block sits between a serial audio port and a decimation datapath. It watches the bit clock and the frame (word) clock of the port and works out how many bit clocks make up one frame. The count must equal one of six supported ratios: 64, 128, 192, 256, 384 or 512. From the bit clock it then derives a microphone clock that always runs at 64 times the frame rate. For valid frame rates of 4 kHz to 96 kHz, that gives 256 kHz to 6.144 MHz. The divide-by-three case, which comes from a ratio of 192, keeps an even duty cycle because the divider counts both bit-clock edges.

Both incoming clocks are sampled on a fast free-running reference clock. The same clock times a silence watchdog. When the bit clock goes quiet for a programmable number of reference cycles, the block marks itself powered down, drops lock and holds the derived clock low. It recovers by itself once the bit clock returns and two clean frames have been measured.

Top module: `bclk_ratio_clkgen`

## Requirements
- R1: While reset is held and just after it is released, `pdmClk` and `pdmTick` are 0, `locked` is 0, `powerDown` is 1 and `ratioCode` is 0.
- R2: The ratio is the number of bit-clock rising edges between two successive frame-clock rising edges. `ratioCode` reads 1, 2, 3, 4, 5 or 6 for a count of 64, 128, 192, 256, 384 or 512, and `locked` is 1 once two back-to-back frames have given the same supported count.
- R3: While locked, `pdmClk` makes exactly 64 rising edges in every frame, whatever the ratio. `pdmTick` is a one-reference-cycle pulse in the cycle where `pdmClk` goes high.
- R4: While locked, each high phase and each low phase of `pdmClk` lasts ratio/64 bit-clock half periods (1, 2, 3, 4, 6 or 8). This includes the odd divide by 3.
- R5: A frame count that is not one of the six supported values makes `locked` 0 and `ratioCode` 0, and keeps `pdmClk` low with no `pdmTick`.
- R6: A single supported frame count that differs from the locked one does not change `ratioCode` or `locked`. The code changes only after two agreeing frames.
- R7: `powerDown` rises once `wdLimit` consecutive reference cycles pass without a sampled bit-clock edge of either polarity. A gap shorter than `wdLimit` never raises it.
- R8: While `powerDown` is 1, `locked` is 0, `ratioCode` is 0 and `pdmClk` is held low. `powerDown` clears on the next bit-clock edge, and lock returns after two fresh agreeing frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock; samples both audio clocks and times the watchdog |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | Serial-port bit clock |
| lrclkIn | input | 1 | Serial-port frame clock |
| wdLimit | input | WD_W (16) | Silence limit in reference cycles before power-down |
| pdmClk | output | 1 | Derived microphone clock, 64 times the frame rate |
| pdmTick | output | 1 | One-cycle pulse at each rising edge of `pdmClk` |
| ratioCode | output | 3 | Detected ratio: 0 none, 1..6 for 64..512 |
| locked | output | 1 | Ratio confirmed and derived clock running |
| powerDown | output | 1 | Bit clock judged absent |

## Verification
The bench drives each of the six supported ratios with clean frames. For each one it checks the reported code, the 64-edges-per-frame count and the exact high and low run lengths, which separates a correct divide-by-3 or divide-by-6 from neighbouring divisors. A frame length of 100 bits tells a real ratio match apart from a loose range check. One injected 256-bit frame inside a 128-bit stream shows whether the two-frame agreement is really applied. Limits one cycle either side of the bit-clock gap, followed by a full stop and restart, show where the watchdog trips and that it recovers.

// File: rtl/bclk_ratio_pkg.sv
package bclk_ratio_pkg;

  localparam int DIV_W = 4;

  typedef enum logic [2:0] {
    RATIO_NONE = 3'd0,
    RATIO_64   = 3'd1,
    RATIO_128  = 3'd2,
    RATIO_192  = 3'd3,
    RATIO_256  = 3'd4,
    RATIO_384  = 3'd5,
    RATIO_512  = 3'd6
  } ratioE;

  // strobes from control to the clock divider
  typedef struct packed {
    logic             bclkEdge;
    logic             run;
    logic [DIV_W-1:0] div;
  } ctrlS;

  function automatic ratioE classify(input int n);
    case (n)
      64:      return RATIO_64;
      128:     return RATIO_128;
      192:     return RATIO_192;
      256:     return RATIO_256;
      384:     return RATIO_384;
      512:     return RATIO_512;
      default: return RATIO_NONE;
    endcase
  endfunction

  // bit clocks per derived clock period = ratio / 64
  function automatic logic [DIV_W-1:0] divOf(input ratioE r);
    case (r)
      RATIO_128: return DIV_W'(2);
      RATIO_192: return DIV_W'(3);
      RATIO_256: return DIV_W'(4);
      RATIO_384: return DIV_W'(6);
      RATIO_512: return DIV_W'(8);
      default:   return DIV_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[LEN-2:0], din};
  end

  assign level = shiftQ[STAGES-1];
  assign rise  = shiftQ[STAGES-1] & ~shiftQ[STAGES];
  assign fall  = ~shiftQ[STAGES-1] & shiftQ[STAGES];
endmodule

// File: rtl/ratio_ctrl.sv
module ratio_ctrl
  import bclk_ratio_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int WD_W  = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bclkRise,
  input  logic            bclkFall,
  input  logic            lrRise,
  input  logic [WD_W-1:0] wdLimit,
  output ctrlS            ctrl,
  output ratioE           ratioCode,
  output logic            locked,
  output logic            powerDown
);
  logic             bclkEdge;
  logic [WD_W-1:0]  idleCnt;
  logic [WD_W:0]    idleNext;
  logic             tripNow;
  logic [CNT_W-1:0] bitCnt;
  logic             seenEdge;
  ratioE            prevCode;
  ratioE            curCode;
  ratioE            frameCode;
  logic             lockedQ;
  logic             pdQ;

  assign bclkEdge  = bclkRise | bclkFall;
  assign idleNext  = {1'b0, idleCnt} + 1'b1;
  assign tripNow   = !bclkEdge && (idleNext >= {1'b0, wdLimit});
  assign frameCode = classify(int'(bitCnt));

  // silence watchdog
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
      pdQ     <= 1'b1;
    end else if (bclkEdge) begin
      idleCnt <= '0;
      pdQ     <= 1'b0;
    end else begin
      if (idleCnt != '1) idleCnt <= idleNext[WD_W-1:0];
      if (tripNow) pdQ <= 1'b1;
    end
  end

  // frame measurement and two-frame agreement
  always_ff @(posedge clk) begin
    if (!rstN || pdQ || tripNow) begin
      bitCnt   <= '0;
      seenEdge <= 1'b0;
      prevCode <= RATIO_NONE;
      curCode  <= RATIO_NONE;
      lockedQ  <= 1'b0;
    end else if (lrRise) begin
      bitCnt   <= bclkRise ? CNT_W'(1) : '0;
      seenEdge <= 1'b1;
      if (seenEdge) begin
        if (frameCode == RATIO_NONE) begin
          lockedQ  <= 1'b0;
          curCode  <= RATIO_NONE;
          prevCode <= RATIO_NONE;
        end else begin
          if (frameCode == prevCode) begin
            lockedQ <= 1'b1;
            curCode <= frameCode;
          end
          prevCode <= frameCode;
        end
      end
    end else if (bclkRise && bitCnt != '1) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign ctrl.bclkEdge = bclkEdge;
  assign ctrl.run      = lockedQ && !pdQ;
  assign ctrl.div      = divOf(curCode);
  assign ratioCode     = curCode;
  assign locked        = lockedQ;
  assign powerDown     = pdQ;

  a_r2_lock_has_code: assert property (@(posedge clk) disable iff (!rstN)
    lockedQ |-> curCode != RATIO_NONE);
  a_r2_lock_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedQ) |-> $past(lrRise));
  a_r6_code_moves_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    (curCode != $past(curCode)) && (curCode != RATIO_NONE) |-> $past(lrRise));
  a_r7_trip_needs_silence: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdQ) |-> !$past(bclkEdge));
  a_r8_pd_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    pdQ |-> !lockedQ);
endmodule

// File: rtl/pdm_divider.sv
module pdm_divider
  import bclk_ratio_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  ctrlS ctrl,
  output logic pdmClk,
  output logic pdmTick
);
  logic [DIV_W-1:0] edgeCnt;
  logic [DIV_W-1:0] cntNext;

  assign cntNext = edgeCnt + 1'b1;

  // toggle after div bit-clock edges of either polarity: half period = div half periods
  always_ff @(posedge clk) begin
    if (!rstN || !ctrl.run) begin
      edgeCnt <= '0;
      pdmClk  <= 1'b0;
      pdmTick <= 1'b0;
    end else begin
      pdmTick <= 1'b0;
      if (ctrl.bclkEdge) begin
        if (cntNext >= ctrl.div) begin
          edgeCnt <= '0;
          pdmClk  <= ~pdmClk;
          pdmTick <= ~pdmClk;
        end else begin
          edgeCnt <= cntNext;
        end
      end
    end
  end

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.run |=> !pdmClk);
  a_r3_tick_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    pdmTick |-> pdmClk && !$past(pdmClk));
  a_r4_toggle_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.run) && (pdmClk != $past(pdmClk)) |-> $past(ctrl.bclkEdge));
endmodule

// File: rtl/bclk_ratio_clkgen.sv
module bclk_ratio_clkgen
  import bclk_ratio_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 10,
  parameter int WD_W        = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bclkIn,
  input  logic            lrclkIn,
  input  logic [WD_W-1:0] wdLimit,
  output logic            pdmClk,
  output logic            pdmTick,
  output logic [2:0]      ratioCode,
  output logic            locked,
  output logic            powerDown
);
  logic  bclkLvl, bclkRise, bclkFall;
  logic  lrLvl, lrRise, lrFall;
  ctrlS  ctrl;
  ratioE code;

  sig_sync #(.STAGES(SYNC_STAGES)) u_bclkSync (
    .clk(clk), .rstN(rstN), .din(bclkIn),
    .level(bclkLvl), .rise(bclkRise), .fall(bclkFall));

  sig_sync #(.STAGES(SYNC_STAGES)) u_lrSync (
    .clk(clk), .rstN(rstN), .din(lrclkIn),
    .level(lrLvl), .rise(lrRise), .fall(lrFall));

  ratio_ctrl #(.CNT_W(CNT_W), .WD_W(WD_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .bclkRise(bclkRise), .bclkFall(bclkFall), .lrRise(lrRise),
    .wdLimit(wdLimit), .ctrl(ctrl), .ratioCode(code),
    .locked(locked), .powerDown(powerDown));

  pdm_divider u_div (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .pdmClk(pdmClk), .pdmTick(pdmTick));

  assign ratioCode = code;

  // levels and frame falls are not needed by this block
  logic unusedOk;
  assign unusedOk = bclkLvl ^ lrLvl ^ lrFall;
endmodule

// File: tb/bclk_ratio_clkgen_tb.sv
module bclk_ratio_clkgen_tb;
  localparam int HP = 4;
  localparam int WD_W = 16;
  localparam int NV = 6;
  // ratio, expected code, expected divisor
  localparam int VEC [NV][3] = '{
    '{64, 1, 1}, '{128, 2, 2}, '{192, 3, 3},
    '{256, 4, 4}, '{384, 5, 6}, '{512, 6, 8}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bclk = 1'b0;
  logic lrclk = 1'b0;
  logic [WD_W-1:0] wdLimit = WD_W'(1000);
  logic pdmClk, pdmTick, locked, powerDown;
  logic [2:0] ratioCode;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  bit genOn = 0;
  int curRatio = 64;
  int glitchRatio = 0;
  bit glitchArm = 0;
  int frameRatio = 64;
  int phase = 0;
  int bitIdx = 0;

  always #2.5 clk = ~clk;

  bclk_ratio_clkgen u_dut (
    .clk(clk), .rstN(rstN), .bclkIn(bclk), .lrclkIn(lrclk),
    .wdLimit(wdLimit), .pdmClk(pdmClk), .pdmTick(pdmTick),
    .ratioCode(ratioCode), .locked(locked), .powerDown(powerDown));

  // serial-port clock generator: frame clock moves on bit-clock falling edges
  always @(negedge clk) begin
    if (genOn) begin
      if (phase == HP - 1) begin
        phase = 0;
        bclk = ~bclk;
        if (!bclk) begin
          bitIdx++;
          if (bitIdx == frameRatio / 2) begin
            bitIdx = 0;
            lrclk = ~lrclk;
            if (lrclk) begin
              frameRatio = glitchArm ? glitchRatio : curRatio;
              glitchArm = 0;
            end
          end
        end
      end else begin
        phase++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitFrames(input int n);
    repeat (n) @(posedge lrclk);
    @(negedge clk);
  endtask

  task automatic countTicks(input int len, output int n);
    n = 0;
    @(posedge lrclk);
    repeat (len) begin
      @(negedge clk);
      n += int'(pdmTick);
    end
  endtask

  task automatic runLengths(output int hi, output int lo);
    hi = 0;
    lo = 0;
    @(negedge clk);
    while (pdmClk) @(negedge clk);
    while (!pdmClk) @(negedge clk);
    while (pdmClk) begin hi++; @(negedge clk); end
    while (!pdmClk) begin lo++; @(negedge clk); end
  endtask

  initial begin
    int n, hi, lo, dev;
    // R1: reset state
    repeat (5) @(negedge clk);
    chk(pdmClk == 0 && pdmTick == 0, "R1", "pdm in reset", int'(pdmClk), 0);
    chk(locked == 0 && ratioCode == 0, "R1", "lock in reset", int'(ratioCode), 0);
    chk(powerDown == 1, "R1", "powerDown in reset", int'(powerDown), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(powerDown == 1 && locked == 0, "R1", "after release", int'(powerDown), 1);
    genOn = 1;

    // R2 R3 R4: vector table walk over all supported ratios
    for (int v = 0; v < NV; v++) begin
      curRatio = VEC[v][0];
      waitFrames(4);
      chk(locked == 1, "R2", "locked", int'(locked), 1);
      chk(int'(ratioCode) == VEC[v][1], "R2", "ratio code", int'(ratioCode), VEC[v][1]);
      countTicks(VEC[v][0] * 2 * HP, n);
      chk(n == 64, "R3", "pdm edges per frame", n, 64);
      runLengths(hi, lo);
      chk(hi == VEC[v][2] * HP, "R4", "pdm high run", hi, VEC[v][2] * HP);
      chk(lo == VEC[v][2] * HP, "R4", "pdm low run", lo, VEC[v][2] * HP);
    end

    // R5: unsupported frame length
    curRatio = 100;
    waitFrames(4);
    chk(locked == 0, "R5", "locked on bad count", int'(locked), 0);
    chk(ratioCode == 0, "R5", "code on bad count", int'(ratioCode), 0);
    countTicks(100 * 2 * HP, n);
    chk(n == 0 && pdmClk == 0, "R5", "pdm edges on bad count", n, 0);

    // R6: one disagreeing frame is ignored
    curRatio = 128;
    waitFrames(4);
    chk(locked == 1 && ratioCode == 2, "R6", "prelock at 128", int'(ratioCode), 2);
    glitchRatio = 256;
    glitchArm = 1;
    dev = 0;
    repeat (10000) begin
      @(negedge clk);
      if (ratioCode != 2 || !locked) dev++;
    end
    chk(dev == 0, "R6", "cycles off 128 lock", dev, 0);
    chk(glitchArm == 0, "R6", "glitch frame sent", int'(glitchArm), 0);

    // R7: watchdog boundary
    curRatio = 64;
    waitFrames(4);
    wdLimit = WD_W'(HP);
    dev = 0;
    repeat (1536) begin
      @(negedge clk);
      if (powerDown) dev++;
    end
    chk(dev == 0, "R7", "trips at limit = gap", dev, 0);
    wdLimit = WD_W'(HP - 1);
    dev = 0;
    repeat (40) begin
      @(negedge clk);
      if (powerDown) dev++;
    end
    chk(dev > 0, "R7", "trips at limit below gap", dev, 1);
    wdLimit = WD_W'(1000);

    // R8: bit clock stops, then returns
    waitFrames(4);
    chk(locked == 1 && powerDown == 0, "R8", "relock before stop", int'(locked), 1);
    genOn = 0;
    repeat (1100) @(negedge clk);
    chk(powerDown == 1, "R8", "powerDown on stop", int'(powerDown), 1);
    chk(locked == 0 && ratioCode == 0, "R8", "lock on stop", int'(ratioCode), 0);
    dev = 0;
    repeat (300) begin
      @(negedge clk);
      if (pdmClk || pdmTick) dev++;
    end
    chk(dev == 0, "R8", "pdm activity while down", dev, 0);
    genOn = 1;
    waitFrames(4);
    chk(powerDown == 0, "R8", "powerDown after restart", int'(powerDown), 0);
    chk(locked == 1 && ratioCode == 1, "R8", "relock after restart", int'(ratioCode), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule